// File: doc/BRIEF.md
# Byte-Stream Bus Master with Read Margin

This block turns an incoming byte stream into transactions on a flat 32-bit memory-mapped bus. Each transaction opens with a command byte that picks the direction and the data width (one to four bytes). A header follows with the start address, an address step and a beat count. Write data bytes are gathered into bus words. For reads, every later byte slot of the stream carries one byte of read data back to the host.

Reads run against a hard deadline. The bus slave must acknowledge a read before the byte slot that sends the first byte of that beat. For every read beat the block reports how many application cycles were left between the acknowledge and that slot. Host software can then retry reads that came close to missing. A read that misses returns 0xFF bytes and a margin of zero. All widths and all address steps, including a step of zero, run at one byte per slot with no extra cycles.

Top module: `bsm_bus_master`

## Requirements
- R1: In a command byte, bit 7 selects a read (1) or a write (0), bits 6:5 hold the beat width in bytes minus one, and bits 4:0 have no effect.
- R2: Seven header bytes follow the command: the start address (4 bytes, least significant first), the address step (1 byte), and the beat count (2 bytes, least significant first). A count of zero ends the transaction with no bus strobe, and the next byte is a command.
- R3: Write bytes fill the data word from the least significant byte up. Lanes above the width are zero. `bus_wr_en` is high for exactly one cycle, namely the cycle after the strobe carrying the last byte of the beat, with one pulse per beat.
- R4: The first beat uses the start address. Each later beat uses the previous address plus the step, modulo 2^32, so a step of zero keeps the address fixed.
- R5: `bus_rd_en` pulses for one cycle, once per beat. The first pulse comes in the cycle after the last header byte's strobe. Each later pulse comes in the cycle after the strobe of the previous beat's last byte slot.
- R6: In a read, each byte strobe after the header is an output slot. `tx_valid` rises in the next cycle with the beat's bytes in order, least significant first. No other strobe raises `tx_valid`.
- R7: An acknowledge counts only if it arrives no later than the cycle before the strobe of the beat's first byte slot. An acknowledge in the cycle of `bus_rd_en` also counts. Otherwise every byte of that beat is 0xFF, and a late acknowledge changes nothing.
- R8: With the first byte of each read beat, `mgn_valid` pulses. `mgn_value` gives the number of cycles strictly between the acknowledge cycle and the first-slot strobe cycle, saturating at 255. It is 0 for a missed beat.
- R9: An acknowledge while no read is outstanding is ignored.
- R10: After reset all outputs are zero and the block waits for a command. `bus_wr_en` and `bus_rd_en` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Application clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_stb | input | 1 | One-cycle strobe: a byte slot of the stream |
| byte_in | input | 8 | Incoming byte, valid with byte_stb |
| tx_valid | output | 1 | Outgoing read byte valid |
| tx_byte | output | 8 | Outgoing read byte |
| mgn_valid | output | 1 | Margin report valid, once per read beat |
| mgn_value | output | 8 | Spare cycles before the deadline |
| bus_addr | output | 32 | Bus address |
| bus_wdata | output | 32 | Bus write data |
| bus_wr_en | output | 1 | Write strobe |
| bus_rd_en | output | 1 | Read strobe |
| bus_rdata | input | 32 | Read data from the slave |
| bus_rd_ack | input | 1 | Read acknowledge from the slave |

## Verification
The assertions check on every cycle that the two bus strobes are exclusive, and that every write strobe, read strobe and outgoing byte follows a byte slot. They also check that each margin report arrives together with an outgoing byte. Only the scenarios can show the remaining behaviour. That includes the byte order of the header and data, the address stepping, the 0xFF fill with acknowledge delays at and past the deadline, the exact margin counts and their saturation, and the discarding of stray or late acknowledges. These are checked against a register-file model whose acknowledge delay is set for each transaction.

// File: rtl/bsm_pkg.sv
// Shared definitions for the byte-stream bus master.
// Assumes a command byte whose direction and width fields sit at fixed bits.
package bsm_pkg;
    typedef enum logic [1:0] {
        ST_CMD = 2'd0,
        ST_HDR = 2'd1,
        ST_WR  = 2'd2,
        ST_RD  = 2'd3
    } bsm_state_e;

    localparam int CMD_RD_BIT = 7;
    localparam int CMD_WID_HI = 6;
    localparam int CMD_WID_LO = 5;
    localparam int STEP_W     = 8;
endpackage

// File: rtl/bsm_margin_ctr.sv
// Saturating cycle counter: restarts at zero on clr and counts up, stopping at all ones.
// Assumes the caller samples it only when a valid acknowledge has restarted it.
module bsm_margin_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    // Count cycles since the last restart, holding at the maximum value.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (clr)        cnt <= '0;
        else if (cnt != '1)  cnt <= cnt + W'(1);
    end
endmodule

// File: rtl/bsm_rd_capture.sv
// Read-data capture: waits for the acknowledge of an issued read and holds its data until
// the deadline slot. Assumes at most one read outstanding. The deadline discards any
// pending or captured read, and an acknowledge in the deadline cycle is too late.
module bsm_rd_capture #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic              deadline,
    input  logic              ack,
    input  logic [DATA_W-1:0] rdata,
    output logic              accept,
    output logic              ready,
    output logic [DATA_W-1:0] data
);
    logic pending;

    assign accept = ack && (pending || issue) && !deadline;

    // Track the outstanding read and latch its data on a timely acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            ready   <= 1'b0;
            data    <= '0;
        end else if (deadline) begin
            pending <= 1'b0;
            ready   <= 1'b0;
        end else if (accept) begin
            pending <= 1'b0;
            ready   <= 1'b1;
            data    <= rdata;
        end else if (issue) begin
            pending <= 1'b1;
        end
    end
endmodule

// File: rtl/bsm_bus_master.sv
// Byte-stream bus master: decodes command and header bytes, runs write and read bursts on a
// flat bus, and returns read bytes with a per-beat margin report. Assumes one byte per
// byte_stb, at most one strobe per cycle, and read slots spaced by at least one idle cycle.
module bsm_bus_master
    import bsm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    parameter int MGN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_stb,
    input  logic [7:0]        byte_in,
    output logic              tx_valid,
    output logic [7:0]        tx_byte,
    output logic              mgn_valid,
    output logic [MGN_W-1:0]  mgn_value,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_wr_en,
    output logic              bus_rd_en,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_rd_ack
);
    localparam int NB      = DATA_W / 8;
    localparam int AB      = ADDR_W / 8;
    localparam int CB      = CNT_W / 8;
    localparam int HDR_LEN = AB + 1 + CB;
    localparam int HIDX_W  = $clog2(HDR_LEN);
    localparam int BIDX_W  = (NB > 1) ? $clog2(NB) : 1;

    bsm_state_e        state;
    logic              is_rd;
    logic [1:0]        wm1;
    logic [HIDX_W-1:0] hidx;
    logic [BIDX_W-1:0] bidx;
    logic [STEP_W-1:0] step;
    logic [CNT_W-1:0]  beats;
    logic [CNT_W-1:0]  cnt_last;
    logic [DATA_W-1:0] rbuf;
    logic              deadline;
    logic              cap_accept;
    logic              cap_ready;
    logic [DATA_W-1:0] cap_data;
    logic [MGN_W-1:0]  mgn_cnt;
    logic              beat_last;

    assign cnt_last  = {byte_in, beats[CNT_W-9:0]};
    assign deadline  = byte_stb && (state == ST_RD) && (bidx == '0);
    assign beat_last = (bidx == BIDX_W'(wm1));

    bsm_rd_capture #(.DATA_W(DATA_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue    (bus_rd_en),
        .deadline (deadline),
        .ack      (bus_rd_ack),
        .rdata    (bus_rdata),
        .accept   (cap_accept),
        .ready    (cap_ready),
        .data     (cap_data)
    );

    bsm_margin_ctr #(.W(MGN_W)) u_mgn (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cap_accept),
        .cnt   (mgn_cnt)
    );

    // Command decode, header capture, burst sequencing and output byte selection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_CMD;
            is_rd     <= 1'b0;
            wm1       <= '0;
            hidx      <= '0;
            bidx      <= '0;
            step      <= '0;
            beats     <= '0;
            rbuf      <= '0;
            bus_addr  <= '0;
            bus_wdata <= '0;
            bus_wr_en <= 1'b0;
            bus_rd_en <= 1'b0;
            tx_valid  <= 1'b0;
            tx_byte   <= '0;
            mgn_valid <= 1'b0;
            mgn_value <= '0;
        end else begin
            bus_wr_en <= 1'b0;
            bus_rd_en <= 1'b0;
            tx_valid  <= 1'b0;
            mgn_valid <= 1'b0;
            if (bus_wr_en) bus_addr <= bus_addr + ADDR_W'(step);
            if (byte_stb) begin
                case (state)
                    ST_CMD: begin
                        is_rd <= byte_in[CMD_RD_BIT];
                        wm1   <= byte_in[CMD_WID_HI:CMD_WID_LO];
                        hidx  <= '0;
                        state <= ST_HDR;
                    end
                    ST_HDR: begin
                        hidx <= hidx + HIDX_W'(1);
                        for (int k = 0; k < AB; k++)
                            if (hidx == HIDX_W'(k)) bus_addr[8*k +: 8] <= byte_in;
                        if (hidx == HIDX_W'(AB)) step <= byte_in;
                        for (int k = 0; k < CB; k++)
                            if (hidx == HIDX_W'(AB + 1 + k)) beats[8*k +: 8] <= byte_in;
                        if (hidx == HIDX_W'(HDR_LEN - 1)) begin
                            bidx <= '0;
                            if (cnt_last == '0) begin
                                state <= ST_CMD;
                            end else if (is_rd) begin
                                state     <= ST_RD;
                                bus_rd_en <= 1'b1;
                            end else begin
                                state <= ST_WR;
                            end
                        end
                    end
                    ST_WR: begin
                        for (int k = 0; k < NB; k++) begin
                            if (bidx == BIDX_W'(k))  bus_wdata[8*k +: 8] <= byte_in;
                            else if (bidx == '0)     bus_wdata[8*k +: 8] <= 8'h00;
                        end
                        if (beat_last) begin
                            bidx      <= '0;
                            bus_wr_en <= 1'b1;
                            beats     <= beats - CNT_W'(1);
                            if (beats == CNT_W'(1)) state <= ST_CMD;
                        end else begin
                            bidx <= bidx + BIDX_W'(1);
                        end
                    end
                    ST_RD: begin
                        tx_valid <= 1'b1;
                        if (bidx == '0) begin
                            mgn_valid <= 1'b1;
                            mgn_value <= cap_ready ? mgn_cnt : '0;
                            rbuf      <= cap_ready ? cap_data : '1;
                            tx_byte   <= cap_ready ? cap_data[7:0] : 8'hFF;
                        end else begin
                            for (int k = 1; k < NB; k++)
                                if (bidx == BIDX_W'(k)) tx_byte <= rbuf[8*k +: 8];
                        end
                        if (beat_last) begin
                            bidx  <= '0;
                            beats <= beats - CNT_W'(1);
                            if (beats == CNT_W'(1)) begin
                                state <= ST_CMD;
                            end else begin
                                bus_rd_en <= 1'b1;
                                bus_addr  <= bus_addr + ADDR_W'(step);
                            end
                        end else begin
                            bidx <= bidx + BIDX_W'(1);
                        end
                    end
                    default: state <= ST_CMD;
                endcase
            end
        end
    end
endmodule

// File: rtl/bsm_checker.sv
// Property checker for the byte-stream bus master, attached to every instance by bind.
// Assumes the same clock and synchronous active-low reset as the design.
module bsm_checker (
    input logic clk,
    input logic rst_n,
    input logic byte_stb,
    input logic bus_wr_en,
    input logic bus_rd_en,
    input logic tx_valid,
    input logic mgn_valid
);
    // R10: the two bus strobes never coincide.
    p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr_en && bus_rd_en));

    // R3: a write strobe always follows a byte slot.
    p_wr_after_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr_en |-> $past(byte_stb));

    // R5: a read strobe always follows a byte slot.
    p_rd_after_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd_en |-> $past(byte_stb));

    // R6: every outgoing byte answers the slot of the previous cycle.
    p_tx_after_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $past(byte_stb));

    // R8: a margin report comes only with an outgoing byte.
    p_margin_with_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mgn_valid |-> tx_valid);
endmodule

bind bsm_bus_master bsm_checker u_bsm_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_stb  (byte_stb),
    .bus_wr_en (bus_wr_en),
    .bus_rd_en (bus_rd_en),
    .tx_valid  (tx_valid),
    .mgn_valid (mgn_valid)
);

// File: tb/tb_bsm_bus_master.sv
// Self-checking bench: register-file slave with a per-transaction acknowledge delay,
// seeded random transactions plus directed corner cases.
module tb_bsm_bus_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_stb = 1'b0;
    logic [7:0]  byte_in = '0;
    logic        tx_valid;
    logic [7:0]  tx_byte;
    logic        mgn_valid;
    logic [7:0]  mgn_value;
    logic [31:0] bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_wr_en;
    logic        bus_rd_en;
    logic [31:0] bus_rdata = '0;
    logic        bus_rd_ack = 1'b0;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [31:0] smem [64];
    logic [31:0] emem [64];
    logic [31:0] wa [64];
    logic [31:0] wd [64];
    logic [31:0] ra [64];
    logic [7:0]  txb [256];
    logic [7:0]  mgv [64];
    int wn = 0, rn = 0, txn = 0, mgn = 0;
    int dly = 0;
    int pend = 0;
    logic [31:0] paddr = '0;
    bit stray = 1'b0;

    always #2 clk = ~clk;

    bsm_bus_master dut (
        .clk(clk), .rst_n(rst_n), .byte_stb(byte_stb), .byte_in(byte_in),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .mgn_valid(mgn_valid), .mgn_value(mgn_value),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
        .bus_rdata(bus_rdata), .bus_rd_ack(bus_rd_ack)
    );

    // Monitor plus register-file slave, acting between clock edges.
    always @(negedge clk) begin
        if (bus_wr_en) begin
            if (wn < 64) begin wa[wn] = bus_addr; wd[wn] = bus_wdata; end
            wn++;
            smem[bus_addr[5:0]] = bus_wdata;
        end
        if (bus_rd_en) begin
            if (rn < 64) ra[rn] = bus_addr;
            rn++;
        end
        if (tx_valid) begin
            if (txn < 256) txb[txn] = tx_byte;
            txn++;
        end
        if (mgn_valid) begin
            if (mgn < 64) mgv[mgn] = mgn_value;
            mgn++;
        end
        bus_rd_ack = 1'b0;
        if (stray) begin
            bus_rd_ack = 1'b1;
            bus_rdata  = 32'h1234_5678;
            stray      = 1'b0;
        end
        if (bus_rd_en) begin
            if (dly == 0) begin
                bus_rd_ack = 1'b1;
                bus_rdata  = smem[bus_addr[5:0]];
                pend       = 0;
            end else begin
                pend  = dly;
                paddr = bus_addr;
            end
        end else if (pend > 0) begin
            pend--;
            if (pend == 0) begin
                bus_rd_ack = 1'b1;
                bus_rdata  = smem[paddr[5:0]];
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One byte slot, then idle so that slots are g+1 cycles apart (g >= 1).
    task automatic put(input logic [7:0] b, input int g);
        @(negedge clk);
        byte_stb = 1'b1;
        byte_in  = b;
        @(negedge clk);
        byte_stb = 1'b0;
        repeat (g - 1) @(negedge clk);
    endtask

    task automatic header(input bit rd, input int w, input logic [4:0] junk,
                          input logic [31:0] a, input logic [7:0] st, input int n, input int g);
        logic [15:0] n16;
        n16 = 16'(n);
        put({rd, 2'(w - 1), junk}, g);
        for (int k = 0; k < 4; k++) put(a[8*k +: 8], g);
        put(st, g);
        put(n16[7:0], g);
        put(n16[15:8], g);
    endtask

    // Full transaction with expectations computed from the requirements.
    task automatic xfer(input bit rd, input int w, input logic [31:0] a, input logic [7:0] st,
                        input int n, input int g, input int d);
        logic [31:0] ew [16];
        logic [31:0] ea;
        logic [7:0]  b;
        bit          miss;
        int          m;
        wn = 0; rn = 0; txn = 0; mgn = 0;
        dly = d;
        header(rd, w, 5'($urandom), a, st, n, g);
        for (int k = 0; k < n; k++) begin
            ew[k] = '0;
            for (int j = 0; j < w; j++) begin
                b = 8'($urandom);
                ew[k][8*j +: 8] = b;
                put(b, g);
            end
        end
        repeat (g + 4) @(negedge clk);
        if (!rd) begin
            chk("R3 write beat count", 32'(wn), 32'(n));
            chk("R6 no output bytes on write", 32'(txn), 0);
            for (int k = 0; k < n && k < 64; k++) begin
                ea = a + 32'(k) * 32'(st);
                chk("R4 write address", wa[k], ea);
                chk("R3 write data", wd[k], ew[k]);
                emem[ea[5:0]] = ew[k];
            end
        end else begin
            miss = (d >= g);
            m = miss ? 0 : ((g - 1 - d) > 255 ? 255 : (g - 1 - d));
            chk("R5 read beat count", 32'(rn), 32'(n));
            chk("R6 output byte count", 32'(txn), 32'(n * w));
            chk("R8 margin report count", 32'(mgn), 32'(n));
            for (int k = 0; k < n && k < 64; k++) begin
                ea = a + 32'(k) * 32'(st);
                chk("R4 read address", ra[k], ea);
                chk(miss ? "R7 missed margin" : "R8 margin value", 32'(mgv[k]), 32'(m));
                for (int j = 0; j < w; j++)
                    chk(miss ? "R7 missed byte fill" : "R6 read byte",
                        32'(txb[k*w + j]), miss ? 32'hFF : 32'(emem[ea[5:0]][8*j +: 8]));
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int g, d, w, n;
        void'($urandom(32'd2024));
        for (int i = 0; i < 64; i++) begin
            smem[i] = 32'hA500_0000 ^ (32'(i) * 32'h0103_0507);
            emem[i] = smem[i];
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk("R10 reset outputs", {tx_valid, mgn_valid, bus_wr_en, bus_rd_en, tx_byte, mgn_value},
            '0);
        chk("R10 reset address", bus_addr, '0);

        // R2: zero count does nothing, next byte is a command
        wn = 0; rn = 0;
        header(1'b0, 2, 5'h1F, 32'h0000_0010, 8'd1, 0, 1);
        repeat (4) @(negedge clk);
        chk("R2 zero count no write", 32'(wn), 0);
        xfer(1'b0, 4, 32'hFFFF_FFFE, 8'd4, 3, 1, 0);   // R4 address wraps
        // R4: step 0 keeps the address, last write wins
        xfer(1'b0, 3, 32'h0000_0020, 8'd0, 3, 2, 0);
        xfer(1'b1, 4, 32'h0000_0020, 8'd0, 2, 2, 1);
        // R8: tightest valid margin and saturation
        xfer(1'b1, 1, 32'h0000_0005, 8'd1, 2, 1, 0);
        xfer(1'b1, 2, 32'h0000_0008, 8'd2, 1, 300, 0);
        // R7: late acknowledge on a four-byte beat
        xfer(1'b1, 4, 32'h0000_0030, 8'd4, 2, 1, 3);
        xfer(1'b1, 2, 32'h0000_0031, 8'd1, 1, 3, 3);
        // R9: stray acknowledge while idle does not fill a later missed read
        stray = 1'b1;
        repeat (4) @(negedge clk);
        xfer(1'b1, 2, 32'h0000_0011, 8'd3, 1, 1, 2);
        chk("R9 stray ack ignored", 32'(txb[0]), 32'hFF);

        // Random mix (R1 reserved bits random in every command)
        for (int t = 0; t < 40; t++) begin
            g = 1 + int'($urandom % 5);
            d = ($urandom % 5 == 0) ? g + int'($urandom % 3) : int'($urandom % 32'(g));
            w = 1 + int'($urandom % 4);
            n = 1 + int'($urandom % 5);
            xfer(1'($urandom), w, $urandom, 8'($urandom % 5), n, g, d);
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule